// File: doc/BRIEF.md
# I2C Target Receiver with Receive Queue

This block is the receive side of an I2C target. It watches the SCL and SDA lines and finds START, repeated START and STOP conditions. It then compares the first byte of each transfer with a 7-bit own address that software can change. If the address matches and the direction bit requests a write, the block pulls SDA low to acknowledge the address. It then acknowledges every data byte and stores each one in an eight-entry receive queue.

Software uses a small register port to reach the block. Through it, software pops bytes, reads the raw interrupt flags, the masked interrupt flags and the status, and sets an interrupt mask, a fill threshold and the own address. The receiver never refuses a byte. If a byte arrives while the queue is full, the block still acknowledges it but throws it away and sets a sticky overflow flag. Software must therefore empty the queue fast enough. SDA is an open-drain line: the block only pulls it low through an output enable.

Top module: `i2c_rx_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and `irq` is 0. The raw flags (offset 1), mask (offset 2), status (offset 3) and threshold (offset 4) read 0. The own address (offset 5, bits 6:0) reads 7'h50.
- R2: A START followed by an address byte whose upper seven bits equal the own address and whose bit 0 is 0 (write) is acknowledged. SDA is held low while SCL is high in the ninth clock, and the block starts pulling SDA low only while the synchronised SCL is low.
- R3: If the address differs or bit 0 is 1 (read), the block does not acknowledge. It then ignores every byte, storing and acknowledging none, until the next START or STOP.
- R4: After a matching address, each data byte is acknowledged and stored. A read of offset 0 returns the oldest stored byte in bits 7:0 and removes it. A read of offset 0 while the queue is empty returns 0 and changes nothing.
- R5: Raw flag bit 2 (receive level) is 1 exactly while the queue holds more bytes than the threshold at offset 4. It clears by itself once reads bring the occupancy down to the threshold or below.
- R6: A byte that arrives while all 8 entries are used is still acknowledged but is discarded, and raw flag bit 1 (overflow) is set. Bit 1 stays set until software reads offset 6. Bytes already stored are unchanged.
- R7: Status bit 3 (offset 3) reads 1 exactly while the queue is not empty.
- R8: Mask bits 2 and 1 (offset 2) enable the matching raw flags, and 0 means masked. `irq` is the OR of the raw flags ANDed with their mask bits. Offset 7 reads the masked flags.
- R9: A repeated START starts address matching again without going idle. A STOP returns the block to idle with SDA released.
- R10: Writing offset 5 sets the own address from bits 6:0, and matching uses the new value from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, pull SDA low |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Register read strobe (pops on offset 0, clears overflow on offset 6) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt |

## Verification
A behavioural master drives four kinds of transfer:
- Several bytes to the correct address, which shows that bytes are stored in order.
- A wrong address and a read-direction address, each followed by data, which shows that the block acknowledges and stores nothing outside its own writes.
- A repeated START that switches from a wrong address to the right one, and a second repeated START inside a valid transfer, which show that matching starts again without a STOP.
- Ten bytes into an eight-entry queue, which separates the overflow drop from back-pressure: every byte must still be acknowledged, while only the first eight can be read back.

A threshold change and a mask change then show the level-based receive flag apart from the sticky overflow flag in `irq`.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_IGNORE
  } rx_state_e;

  localparam int BYTE_W = 8;
  localparam int ADDR7_W = 7;

  localparam logic [2:0] REG_DATA   = 3'd0;
  localparam logic [2:0] REG_RAW    = 3'd1;
  localparam logic [2:0] REG_MASK   = 3'd2;
  localparam logic [2:0] REG_STATUS = 3'd3;
  localparam logic [2:0] REG_THRESH = 3'd4;
  localparam logic [2:0] REG_OWN    = 3'd5;
  localparam logic [2:0] REG_OVCLR  = 3'd6;
  localparam logic [2:0] REG_INTR   = 3'd7;

  localparam int RAW_LEVEL_BIT = 2;
  localparam int RAW_OVF_BIT   = 1;
  localparam int STAT_NE_BIT   = 3;

endpackage

// File: rtl/i2c_rx_linemon.sv
module i2c_rx_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_ff;
  logic [SYNC_STAGES-1:0] sda_ff;
  logic                   scl_q;
  logic                   sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic                sda_s,
  input  logic [ADDR7_W-1:0]  own_addr,
  output logic                push,
  output logic [BYTE_W-1:0]   push_data,
  output logic                sda_oe,
  output rx_state_e           state
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_e          st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [BYTE_W-1:0]  sh_q, sh_n;
  logic               drv_q, drv_n;
  logic               push_q, push_n;
  logic [BYTE_W-1:0]  byte_in;
  logic               addr_hit;

  assign byte_in  = {sh_q[BYTE_W-2:0], sda_s};
  assign addr_hit = (byte_in[BYTE_W-1:1] == own_addr) && !byte_in[0];

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    drv_n  = drv_q;
    push_n = 1'b0;
    if (stop_det) begin
      st_n  = ST_IDLE;
      drv_n = 1'b0;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      drv_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (scl_rise) begin
          sh_n = byte_in;
          if (cnt_q == LAST_BIT) st_n = addr_hit ? ST_ACK_SETUP : ST_IGNORE;
          else                   cnt_n = cnt_q + 1'b1;
        end
        ST_DATA: if (scl_rise) begin
          sh_n = byte_in;
          if (cnt_q == LAST_BIT) begin
            push_n = 1'b1;
            st_n   = ST_ACK_SETUP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_ACK_SETUP: if (scl_fall) begin
          drv_n = 1'b1;
          st_n  = ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          drv_n = 1'b0;
          cnt_n = '0;
          st_n  = ST_DATA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      drv_q  <= 1'b0;
      push_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      drv_q  <= drv_n;
      push_q <= push_n;
    end
  end

  assign push      = push_q;
  assign push_data = sh_q;
  assign sda_oe    = drv_q;
  assign state     = st_q;

endmodule

// File: rtl/i2c_rx_fifo.sv
module i2c_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    cnt_n = cnt_q;
    unique case ({do_push, do_pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_n;
    end
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target
  import i2c_rx_pkg::*;
#(
  parameter int                 DEPTH        = 8,
  parameter int                 SYNC_STAGES  = 2,
  parameter logic [ADDR7_W-1:0] OWN_ADDR_RST = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] reg_addr,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);

  localparam int CW = $clog2(DEPTH + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic push, pop, ovf_clr, ovf_set;
  logic [BYTE_W-1:0] push_data, head;
  logic fifo_full, fifo_empty;
  logic [CW-1:0] fifo_cnt;
  rx_state_e state;

  logic [ADDR7_W-1:0] own_q;
  logic [1:0]         mask_q;
  logic [CW-1:0]      thr_q;
  logic               ovf_q, ovf_n;
  logic [7:0]         raw_w, mask_w, intr_w;

  i2c_rx_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .own_addr(own_q), .push(push), .push_data(push_data),
    .sda_oe(sda_oe), .state(state)
  );

  i2c_rx_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .head(head), .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt)
  );

  assign pop     = reg_rd && (reg_addr == REG_DATA);
  assign ovf_clr = reg_rd && (reg_addr == REG_OVCLR);
  assign ovf_set = push && fifo_full;

  // a new drop wins over a clear in the same cycle
  always_comb begin
    ovf_n = ovf_q;
    if (ovf_clr) ovf_n = 1'b0;
    if (ovf_set) ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= OWN_ADDR_RST;
      mask_q <= '0;
      thr_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == REG_OWN)    own_q  <= reg_wdata[ADDR7_W-1:0];
      if (reg_wr && reg_addr == REG_MASK)   mask_q <= {reg_wdata[RAW_LEVEL_BIT], reg_wdata[RAW_OVF_BIT]};
      if (reg_wr && reg_addr == REG_THRESH) thr_q  <= reg_wdata[CW-1:0];
      ovf_q <= ovf_n;
    end
  end

  always_comb begin
    raw_w  = '0;
    mask_w = '0;
    raw_w[RAW_LEVEL_BIT]  = (fifo_cnt > thr_q);
    raw_w[RAW_OVF_BIT]    = ovf_q;
    mask_w[RAW_LEVEL_BIT] = mask_q[1];
    mask_w[RAW_OVF_BIT]   = mask_q[0];
    intr_w = raw_w & mask_w;
  end

  assign irq = |intr_w;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_DATA:   reg_rdata = fifo_empty ? '0 : head;
      REG_RAW:    reg_rdata = raw_w;
      REG_MASK:   reg_rdata = mask_w;
      REG_STATUS: reg_rdata[STAT_NE_BIT] = ~fifo_empty;
      REG_THRESH: reg_rdata = 8'(thr_q);
      REG_OWN:    reg_rdata = 8'(own_q);
      REG_OVCLR:  reg_rdata = '0;
      REG_INTR:   reg_rdata = intr_w;
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/i2c_rx_target_chk.sv
module i2c_rx_target_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          stop_det,
  input logic          push,
  input logic          pop,
  input logic          fifo_empty,
  input logic [CW-1:0] fifo_cnt,
  input logic          ovf_set,
  input logic          ovf_q,
  input logic          ovf_clr
);

  // R2
  ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R6
  ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_q);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R6
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fifo_empty && !push) |=> $stable(fifo_cnt));

endmodule

bind i2c_rx_target i2c_rx_target_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .stop_det(stop_det), .push(push), .pop(pop), .fifo_empty(fifo_empty),
  .fifo_cnt(fifo_cnt), .ovf_set(ovf_set), .ovf_q(ovf_q), .ovf_clr(ovf_clr)
);

// File: tb/tb_i2c_rx_target.sv
`timescale 1ns/1ps
module tb_i2c_rx_target;

  localparam int DEPTH = 8;
  localparam int HALF  = 10;

  logic clk, rst_n;
  logic scl_m, sda_m, sda_line;
  logic sda_oe, irq;
  logic [2:0] reg_addr;
  logic reg_rd, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;

  int compared = 0;
  int mismatched = 0;
  bit cmp_en = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mq[$];
  bit   m_ovf;
  logic [7:0] m_mask;
  int   m_thr;

  assign sda_line = sda_m & ~sda_oe;

  i2c_rx_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_irq();
    return ((m_mask[2] && mq.size() > m_thr) || (m_mask[1] && m_ovf)) ? 1 : 0;
  endfunction

  // per-clock comparison while the bus is quiet
  always @(negedge clk) begin
    #3;
    if (cmp_en && rst_n && !done) begin
      chk("R8 irq", int'(irq), exp_irq());
      chk("R9 idle sda_oe", int'(sda_oe), 0);
    end
  end

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    #2 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
    if (a == 3'd0 && mq.size() > 0) void'(mq.pop_front());
    if (a == 3'd6) m_ovf = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    if (a == 3'd2) m_mask = d & 8'h06;
    if (a == 3'd4) m_thr = int'(d[3:0]);
  endtask

  task automatic hold(); repeat (HALF) @(negedge clk); endtask

  task automatic bus_start();
    cmp_en = 0;
    sda_m = 1; scl_m = 1; hold();
    sda_m = 0; hold();
    scl_m = 0; hold();
  endtask

  task automatic bus_rstart();
    sda_m = 1; hold();
    scl_m = 1; hold();
    sda_m = 0; hold();
    scl_m = 0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 0; hold();
    scl_m = 1; hold();
    sda_m = 1; hold();
    repeat (10) @(negedge clk);
    cmp_en = 1;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold();
      scl_m = 1; hold();
      scl_m = 0;
    end
    sda_m = 1; hold();
    scl_m = 1;
    repeat (HALF/2) @(negedge clk);
    acked = (sda_line == 0);
    repeat (HALF - HALF/2) @(negedge clk);
    scl_m = 0;
  endtask

  task automatic model_push(input logic [7:0] b);
    if (mq.size() < DEPTH) mq.push_back(b);
    else m_ovf = 1;
  endtask

  logic [7:0] d;
  bit ak;

  initial begin
    rst_n = 0; scl_m = 1; sda_m = 1;
    reg_addr = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    m_ovf = 0; m_mask = 0; m_thr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp_en = 1;

    // R1 reset values
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 irq", int'(irq), 0);
    rd(3'd1, d); chk("R1 raw", d, 0);
    rd(3'd2, d); chk("R1 mask", d, 0);
    rd(3'd3, d); chk("R1 status", d, 0);
    rd(3'd4, d); chk("R1 thresh", d, 0);
    rd(3'd5, d); chk("R1 own", d, 8'h50);

    // R10 program own address, R8 enable both flags
    wr(3'd5, 8'h3A);
    rd(3'd5, d); chk("R10 own readback", d, 8'h3A);
    wr(3'd2, 8'h06);
    rd(3'd2, d); chk("R8 mask readback", d, 8'h06);

    // R2/R4 basic write of two bytes
    bus_start();
    send_byte({7'h3A, 1'b0}, ak); chk("R2 addr ack", ak, 1);
    send_byte(8'hA5, ak); chk("R4 data ack", ak, 1); model_push(8'hA5);
    send_byte(8'h3C, ak); chk("R4 data ack", ak, 1); model_push(8'h3C);
    bus_stop();
    rd(3'd3, d); chk("R7 not empty", d, 8'h08);
    rd(3'd1, d); chk("R5 level set", d, 8'h04);
    rd(3'd7, d); chk("R8 masked", d, 8'h04);
    rd(3'd0, d); chk("R4 first byte", d, 8'hA5);
    rd(3'd0, d); chk("R4 second byte", d, 8'h3C);
    rd(3'd3, d); chk("R7 empty", d, 0);
    rd(3'd1, d); chk("R5 level clear", d, 0);
    rd(3'd0, d); chk("R4 empty pop", d, 0);
    rd(3'd3, d); chk("R4 empty pop no effect", d, 0);

    // R3 wrong address, then read direction
    bus_start();
    send_byte({7'h3B, 1'b0}, ak); chk("R3 wrong addr nack", ak, 0);
    send_byte(8'h77, ak); chk("R3 ignored data nack", ak, 0);
    bus_stop();
    rd(3'd3, d); chk("R3 nothing stored", d, 0);
    bus_start();
    send_byte({7'h3A, 1'b1}, ak); chk("R3 read dir nack", ak, 0);
    send_byte(8'h66, ak); chk("R3 ignored data nack", ak, 0);
    bus_stop();
    rd(3'd3, d); chk("R3 nothing stored", d, 0);

    // R9 repeated start from ignore to match, R5 threshold 2
    wr(3'd4, 8'h02);
    bus_start();
    send_byte({7'h11, 1'b0}, ak); chk("R3 wrong addr nack", ak, 0);
    bus_rstart();
    send_byte({7'h3A, 1'b0}, ak); chk("R9 rstart ack", ak, 1);
    send_byte(8'h01, ak); chk("R4 data ack", ak, 1); model_push(8'h01);
    send_byte(8'h02, ak); chk("R4 data ack", ak, 1); model_push(8'h02);
    bus_rstart();
    send_byte({7'h3A, 1'b0}, ak); chk("R9 second rstart ack", ak, 1);
    send_byte(8'h03, ak); chk("R4 data ack", ak, 1); model_push(8'h03);
    bus_stop();
    rd(3'd1, d); chk("R5 above thresh", d, 8'h04);
    rd(3'd0, d); chk("R4 byte order", d, 8'h01);
    rd(3'd1, d); chk("R5 at thresh", d, 0);
    rd(3'd0, d); chk("R4 byte order", d, 8'h02);
    rd(3'd0, d); chk("R4 byte order", d, 8'h03);
    wr(3'd4, 8'h00);

    // R6 overflow: ten bytes into eight entries
    bus_start();
    send_byte({7'h3A, 1'b0}, ak); chk("R2 addr ack", ak, 1);
    for (int i = 0; i < 10; i++) begin
      send_byte(8'h10 + 8'(i), ak);
      chk("R6 ack while full", ak, 1);
      model_push(8'h10 + 8'(i));
    end
    bus_stop();
    rd(3'd1, d); chk("R6 ovf raw", d, 8'h06);
    for (int i = 0; i < 8; i++) begin
      rd(3'd0, d); chk("R6 kept bytes", d, 8'h10 + 8'(i));
    end
    rd(3'd1, d); chk("R6 ovf sticky", d, 8'h02);
    // R8 mask the overflow, irq must drop
    wr(3'd2, 8'h04);
    chk("R8 masked ovf irq", int'(irq), 0);
    rd(3'd7, d); chk("R8 masked word", d, 0);
    wr(3'd2, 8'h06);
    chk("R8 unmasked ovf irq", int'(irq), 1);
    rd(3'd6, d);
    rd(3'd1, d); chk("R6 ovf cleared", d, 0);
    chk("R8 irq after clear", int'(irq), 0);

    // R10 address change takes effect
    wr(3'd5, 8'h21);
    bus_start();
    send_byte({7'h3A, 1'b0}, ak); chk("R10 old addr nack", ak, 0);
    bus_rstart();
    send_byte({7'h21, 1'b0}, ak); chk("R10 new addr ack", ak, 1);
    send_byte(8'hC3, ak); chk("R4 data ack", ak, 1); model_push(8'hC3);
    bus_stop();
    chk("R9 idle release", int'(sda_oe), 0);
    rd(3'd0, d); chk("R10 byte via new addr", d, 8'hC3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule